// File: doc/BRIEF.md
# Grade Binning Sorter Sequencer

The block sequences a component handler that sorts parts into tolerance grades. A run is armed by a one-cycle `run_i` pulse. For each part it waits for a rising edge on one selected start line. It then waits a programmable start delay and raises `meas_req_o`. It takes one signed measurement on a single-cycle `meas_valid_i` and grades that value against up to four nested limit pairs. The resulting 4-bit bin pattern is driven to the handler, and the block waits a programmable end delay before it listens for the next part.

Grading is a first-failure cascade. Stage 0 is the widest band, for example ±20 %, and the narrowest band, for example ±1 %, comes last. The first active stage whose band does not contain the value selects that stage's own pattern. A separate pass pattern is driven only when every active stage passes. After the programmed number of parts the block goes idle and flags completion. A typical run covers 100 parts with start line 5 selected.

Top module: `grade_sorter`

## Requirements
- R1: After reset `pat_o` is 0000, and `done_o`, `busy_o` and `meas_req_o` are all low.
- R2: A `run_i` pulse while idle with `comp_count_i` > 0 clears `done_o` and raises `busy_o`. With `comp_count_i` = 0 it sets `done_o` on the next edge and `busy_o` stays low.
- R3: Only a rising edge on `start_lines_i[line_sel_i]` starts a part, after a two-flop synchronizer. `meas_req_o` becomes visible after the (`start_dly_i`+4)-th rising clock edge, counted from the first edge that samples the line high. Edges on other lines have no effect.
- R4: A stage fails when the measurement, compared as signed 32-bit, is strictly above its high limit or strictly below its low limit. A value equal to either limit passes, and the same pattern is used for both sides.
- R5: Stage i uses limits `lim_hi_i[32i+31:32i]` and `lim_lo_i[32i+31:32i]`. Stages are checked from index 0 (widest) upward. The first failing stage drives `fail_pat_i[4i+3:4i]` on `pat_o`, on the edge that captures `meas_valid_i`.
- R6: Only stages with index below `n_stages_i` are active. If all active stages pass, or if `n_stages_i` = 0, `pat_o` takes `pass_pat_i`.
- R7: `pat_o` holds its value until the next accepted measurement. A `meas_valid_i` while `meas_req_o` is low is ignored.
- R8: The end delay starts at the capture edge. A start edge is accepted only if the sequencer first sees it on the (`end_dly_i`+2)-th edge after the capture edge or later. Earlier start edges are dropped.
- R9: Start edges that arrive during the start delay or while `meas_req_o` is high are ignored.
- R10: After `comp_count_i` parts and the last end delay, `done_o` rises and `busy_o` falls. Later start edges are ignored until the next `run_i`.
- R11: A `run_i` pulse while busy is ignored, and the part count continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Arms a run when idle |
| comp_count_i | input | 16 | Parts per run |
| line_sel_i | input | 3 | Index of the start line |
| start_lines_i | input | 8 | Asynchronous digital input lines |
| start_dly_i | input | 24 | Start delay in clock cycles |
| end_dly_i | input | 24 | End delay in clock cycles |
| n_stages_i | input | 3 | Number of active stages (0..4) |
| lim_hi_i | input | 128 | Packed signed high limits, stage 0 in the low word |
| lim_lo_i | input | 128 | Packed signed low limits |
| fail_pat_i | input | 16 | Packed fail patterns, stage 0 in the low nibble |
| pass_pat_i | input | 4 | All-pass pattern |
| meas_i | input | 32 | Signed measurement |
| meas_valid_i | input | 1 | One-cycle measurement strobe |
| pat_o | output | 4 | Handler bin pattern |
| meas_req_o | output | 1 | Waiting for a measurement |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete |

## Verification
The end of a part's end delay and the arrival of the next start edge can fall on the same clock edge. The bench provokes this by sending a measurement and then raising the start line after a counted number of cycles. In one case the sequencer sees the edge exactly on its last end-delay cycle, and the edge must be lost: `meas_req_o` stays low over a long window. In the other case the line rises one cycle later, and the edge must be accepted. The pair pins the acceptance boundary of R8 to a single cycle.

// File: rtl/grade_sorter_pkg.sv
package grade_sorter_pkg;
  localparam int unsigned GS_PAT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SDLY,
    ST_MEAS,
    ST_EDLY
  } gs_state_e;
endpackage

// File: rtl/gs_start_sync.sv
module gs_start_sync #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 rise_o
);
  logic [NUM_LINES-1:0] s1_q, s2_q;
  logic                 prev_q;
  logic                 pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= lines_i;
      s2_q   <= s1_q;
      prev_q <= pick;
    end
  end

  assign pick   = s2_q[sel_i];
  assign rise_o = pick & ~prev_q;
endmodule

// File: rtl/gs_delay_timer.sv
module gs_delay_timer #(
  parameter int unsigned DLY_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] val_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - DLY_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/gs_grade_chain.sv
module gs_grade_chain #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned MEAS_W     = 32,
  parameter int unsigned PAT_W      = 4,
  localparam int unsigned ST_W = $clog2(NUM_STAGES + 1)
) (
  input  logic [MEAS_W-1:0]            meas_i,
  input  logic [NUM_STAGES*MEAS_W-1:0] lim_hi_i,
  input  logic [NUM_STAGES*MEAS_W-1:0] lim_lo_i,
  input  logic [NUM_STAGES*PAT_W-1:0]  fail_pat_i,
  input  logic [PAT_W-1:0]             pass_pat_i,
  input  logic [ST_W-1:0]              n_stages_i,
  output logic [PAT_W-1:0]             pat_o
);
  logic [NUM_STAGES-1:0] fail_v;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic signed [MEAS_W-1:0] hi, lo, v;
    logic                     active;
    assign hi        = lim_hi_i[g*MEAS_W +: MEAS_W];
    assign lo        = lim_lo_i[g*MEAS_W +: MEAS_W];
    assign v         = meas_i;
    assign active    = n_stages_i > ST_W'(g);
    assign fail_v[g] = active & ((v > hi) | (v < lo));
  end

  // lowest failing index wins: widest band is reported first
  always_comb begin
    pat_o = pass_pat_i;
    for (int i = NUM_STAGES - 1; i >= 0; i--) begin
      if (fail_v[i]) pat_o = fail_pat_i[i*PAT_W +: PAT_W];
    end
  end
endmodule

// File: rtl/grade_sorter.sv
module grade_sorter
  import grade_sorter_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned MEAS_W     = 32,
  parameter int unsigned NUM_LINES  = 8,
  parameter int unsigned DLY_W      = 24,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned PAT_W = GS_PAT_W,
  localparam int unsigned SEL_W = $clog2(NUM_LINES),
  localparam int unsigned ST_W  = $clog2(NUM_STAGES + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_i,
  input  logic [CNT_W-1:0]             comp_count_i,
  input  logic [SEL_W-1:0]             line_sel_i,
  input  logic [NUM_LINES-1:0]         start_lines_i,
  input  logic [DLY_W-1:0]             start_dly_i,
  input  logic [DLY_W-1:0]             end_dly_i,
  input  logic [ST_W-1:0]              n_stages_i,
  input  logic [NUM_STAGES*MEAS_W-1:0] lim_hi_i,
  input  logic [NUM_STAGES*MEAS_W-1:0] lim_lo_i,
  input  logic [NUM_STAGES*PAT_W-1:0]  fail_pat_i,
  input  logic [PAT_W-1:0]             pass_pat_i,
  input  logic [MEAS_W-1:0]            meas_i,
  input  logic                         meas_valid_i,
  output logic [PAT_W-1:0]             pat_o,
  output logic                         meas_req_o,
  output logic                         busy_o,
  output logic                         done_o
);
  gs_state_e         state_q;
  logic [CNT_W-1:0]  parts_q;
  logic              done_q;
  logic [PAT_W-1:0]  pat_q;
  logic              rise;
  logic              tmr_zero;
  logic              tmr_load;
  logic [DLY_W-1:0]  tmr_val;
  logic [PAT_W-1:0]  grade_pat;
  logic              take_meas;

  gs_start_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (start_lines_i),
    .sel_i   (line_sel_i),
    .rise_o  (rise)
  );

  gs_grade_chain #(
    .NUM_STAGES (NUM_STAGES),
    .MEAS_W     (MEAS_W),
    .PAT_W      (PAT_W)
  ) u_chain (
    .meas_i     (meas_i),
    .lim_hi_i   (lim_hi_i),
    .lim_lo_i   (lim_lo_i),
    .fail_pat_i (fail_pat_i),
    .pass_pat_i (pass_pat_i),
    .n_stages_i (n_stages_i),
    .pat_o      (grade_pat)
  );

  assign take_meas = (state_q == ST_MEAS) && meas_valid_i;
  assign tmr_load  = ((state_q == ST_WAIT) && rise) || take_meas;
  assign tmr_val   = (state_q == ST_WAIT) ? start_dly_i : end_dly_i;

  gs_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      parts_q <= '0;
      done_q  <= 1'b0;
      pat_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (run_i) begin
            parts_q <= '0;
            if (comp_count_i == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: if (rise) state_q <= ST_SDLY;
        ST_SDLY: if (tmr_zero) state_q <= ST_MEAS;
        ST_MEAS: begin
          if (meas_valid_i) begin
            pat_q   <= grade_pat;
            parts_q <= parts_q + CNT_W'(1);
            state_q <= ST_EDLY;
          end
        end
        ST_EDLY: begin
          if (tmr_zero) begin
            if (parts_q >= comp_count_i) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pat_o      = pat_q;
  assign meas_req_o = (state_q == ST_MEAS);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/grade_sorter_chk.sv
module grade_sorter_chk #(
  parameter int unsigned MEAS_W = 32,
  parameter int unsigned PAT_W  = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ST_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic [CNT_W-1:0]  comp_count_i,
  input logic [ST_W-1:0]   n_stages_i,
  input logic [MEAS_W-1:0] lim_hi0,
  input logic [PAT_W-1:0]  fail_pat0,
  input logic [MEAS_W-1:0] meas_i,
  input logic              meas_valid_i,
  input logic [PAT_W-1:0]  pat_o,
  input logic              meas_req_o,
  input logic              busy_o,
  input logic              done_o
);
  AST_PAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pat_o) |-> $past(meas_req_o && meas_valid_i)); // R7

  AST_WIDEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && meas_valid_i && n_stages_i != '0 &&
     $signed(meas_i) > $signed(lim_hi0)) |=> pat_o == $past(fail_pat0)); // R5

  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && meas_valid_i) |=> (!meas_req_o && busy_o)); // R8

  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o |-> busy_o); // R9

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !meas_req_o)); // R10

  AST_ZERO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && run_i && comp_count_i == '0) |=> (done_o && !busy_o)); // R2
endmodule

bind grade_sorter grade_sorter_chk #(
  .MEAS_W (MEAS_W),
  .PAT_W  (PAT_W),
  .CNT_W  (CNT_W),
  .ST_W   (ST_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run_i),
  .comp_count_i (comp_count_i),
  .n_stages_i   (n_stages_i),
  .lim_hi0      (lim_hi_i[MEAS_W-1:0]),
  .fail_pat0    (fail_pat_i[PAT_W-1:0]),
  .meas_i       (meas_i),
  .meas_valid_i (meas_valid_i),
  .pat_o        (pat_o),
  .meas_req_o   (meas_req_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/grade_sorter_tb.sv
module grade_sorter_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         run_i = 1'b0;
  logic [15:0]  comp_count_i = 16'd100;
  logic [2:0]   line_sel_i = 3'd5;
  logic [7:0]   start_lines_i = '0;
  logic [23:0]  start_dly_i = '0;
  logic [23:0]  end_dly_i = 24'd3;
  logic [2:0]   n_stages_i = 3'd4;
  logic [127:0] lim_hi_i, lim_lo_i;
  logic [15:0]  fail_pat_i;
  logic [3:0]   pass_pat_i = 4'd4;
  logic [31:0]  meas_i = '0;
  logic         meas_valid_i = 1'b0;
  logic [3:0]   pat_o;
  logic         meas_req_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  grade_sorter u_dut (
    .clk_i, .rst_ni, .run_i, .comp_count_i, .line_sel_i, .start_lines_i,
    .start_dly_i, .end_dly_i, .n_stages_i, .lim_hi_i, .lim_lo_i,
    .fail_pat_i, .pass_pat_i, .meas_i, .meas_valid_i,
    .pat_o, .meas_req_o, .busy_o, .done_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_default_limits();
    lim_hi_i = {32'sd1010, 32'sd1050, 32'sd1100, 32'sd1200};
    lim_lo_i = {32'sd990,  32'sd950,  32'sd900,  32'sd800};
    fail_pat_i = {4'd6, 4'd9, 4'd3, 4'd15};
    pass_pat_i = 4'd4;
    n_stages_i = 3'd4;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    start_lines_i = '0;
    run_i = 1'b0;
    meas_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic start_run(input int cnt);
    comp_count_i = 16'(cnt);
    @(negedge clk_i) run_i = 1'b1;
    @(negedge clk_i) run_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i) start_lines_i[5] = 1'b1;
    repeat (3) @(negedge clk_i);
    start_lines_i[5] = 1'b0;
  endtask

  task automatic wait_req(output bit got, input int maxc);
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (meas_req_o) begin
        got = 1'b1;
        break;
      end
      @(negedge clk_i);
    end
    if (meas_req_o) got = 1'b1;
  endtask

  task automatic measure(input int v);
    meas_i = 32'(v);
    meas_valid_i = 1'b1;
    @(negedge clk_i);
    meas_valid_i = 1'b0;
  endtask

  task automatic do_part(input int v, input int exp, input string tag);
    bit got;
    pulse_start();
    wait_req(got, 200);
    chk(got, {tag, " meas_req"}, int'(got), 1);
    measure(v);
    chk(pat_o == 4'(exp), tag, int'(pat_o), exp);
    repeat (int'(end_dly_i) + 3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    chk(pat_o == 4'd0, "R1 pat_o", int'(pat_o), 0);
    chk({done_o, busy_o, meas_req_o} == 3'b000, "R1 flags",
        int'({done_o, busy_o, meas_req_o}), 0);
  endtask

  task automatic t_timing();
    int c;
    do_reset();
    set_default_limits();
    start_dly_i = 24'd7;
    start_run(5);
    chk(busy_o && !done_o, "R2 run armed", int'({busy_o, done_o}), 2);
    @(negedge clk_i) start_lines_i[2] = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(!meas_req_o, "R3 other line ignored", int'(meas_req_o), 0);
    start_lines_i[2] = 1'b0;
    start_lines_i[5] = 1'b1;
    c = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      c++;
      if (meas_req_o) break;
    end
    chk(c == 11, "R3 start latency", c, 11);
    start_lines_i[5] = 1'b0;
    measure(1000);
    chk(pat_o == 4'd4, "R6 all pass", int'(pat_o), 4);
  endtask

  task automatic t_grades();
    int vals[10] = '{1300, 700, 1150, 1200, 800, 940, 1040, 1011, 1010, 1000};
    int exps[10] = '{15, 15, 3, 3, 3, 9, 6, 6, 4, 4};
    do_reset();
    set_default_limits();
    start_dly_i = 24'd2;
    end_dly_i = 24'd3;
    start_run(100);
    for (int i = 0; i < 10; i++) do_part(vals[i], exps[i], "R4 R5 grade");
    meas_i = 32'd1300;
    meas_valid_i = 1'b1;
    @(negedge clk_i) meas_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(pat_o == 4'd4, "R7 stray valid ignored", int'(pat_o), 4);
  endtask

  task automatic t_stages();
    do_reset();
    set_default_limits();
    start_dly_i = 24'd1;
    start_run(100);
    n_stages_i = 3'd2;
    do_part(1020, 4, "R6 two stages");
    do_part(1150, 3, "R6 two stages fail");
    n_stages_i = 3'd0;
    do_part(5000, 4, "R6 no stages");
    n_stages_i = 3'd1;
    lim_hi_i[31:0] = 32'sd100;
    lim_lo_i[31:0] = -32'sd100;
    do_part(-50, 4, "R4 signed pass");
    do_part(-101, 15, "R4 signed below");
    do_part(101, 15, "R4 signed above");
    do_part(-100, 4, "R4 low edge");
  endtask

  task automatic t_end_window();
    bit got;
    do_reset();
    set_default_limits();
    start_dly_i = 24'd0;
    end_dly_i = 24'd5;
    start_run(10);
    pulse_start();
    wait_req(got, 100);
    measure(1000);
    repeat (3) @(negedge clk_i);
    start_lines_i[5] = 1'b1;
    repeat (30) @(negedge clk_i);
    chk(!meas_req_o, "R8 edge on last end-delay cycle dropped", int'(meas_req_o), 0);
    start_lines_i[5] = 1'b0;
    repeat (3) @(negedge clk_i);
    pulse_start();
    wait_req(got, 100);
    chk(got, "R8 waiting after drop", int'(got), 1);
    measure(1000);
    repeat (4) @(negedge clk_i);
    start_lines_i[5] = 1'b1;
    wait_req(got, 30);
    chk(got, "R8 edge one cycle later accepted", int'(got), 1);
    start_lines_i[5] = 1'b0;
  endtask

  task automatic t_start_ignored();
    bit got;
    do_reset();
    set_default_limits();
    start_dly_i = 24'd20;
    end_dly_i = 24'd3;
    start_run(10);
    pulse_start();
    pulse_start();
    wait_req(got, 100);
    chk(got, "R9 req after delay", int'(got), 1);
    pulse_start();
    chk(meas_req_o, "R9 req held", int'(meas_req_o), 1);
    measure(1000);
    repeat (60) @(negedge clk_i);
    chk(!meas_req_o, "R9 extra edges ignored", int'(meas_req_o), 0);
  endtask

  task automatic t_count_done();
    bit got;
    do_reset();
    set_default_limits();
    start_dly_i = 24'd0;
    end_dly_i = 24'd3;
    start_run(0);
    chk(done_o && !busy_o, "R2 zero count done", int'({done_o, busy_o}), 2);
    start_run(3);
    chk(!done_o && busy_o, "R2 run clears done", int'({done_o, busy_o}), 1);
    do_part(1000, 4, "R10 part1");
    @(negedge clk_i) run_i = 1'b1;
    @(negedge clk_i) run_i = 1'b0;
    do_part(1300, 15, "R11 part2");
    chk(!done_o, "R11 not done early", int'(done_o), 0);
    do_part(1000, 4, "R10 part3");
    chk(done_o && !busy_o, "R10 done after count", int'({done_o, busy_o}), 2);
    pulse_start();
    wait_req(got, 20);
    chk(!got, "R10 start ignored when done", int'(got), 0);
    chk(pat_o == 4'd4, "R7 pattern held", int'(pat_o), 4);
  endtask

  initial begin
    set_default_limits();
    t_reset();
    t_timing();
    t_grades();
    t_stages();
    t_end_window();
    t_start_ignored();
    t_count_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule